// File: doc/BRIEF.md
# Single-Line Cache Coherence Controller

This block is the cache-side engine for one line in a directory-based coherence scheme. It keeps the line's state and data. It serves processor loads and stores, reacts to requests and replies from the home node, and carries out voluntary invalidate, writeback and flush commands. It sends its own requests and responses back toward the home node. Several copies of the block, together with the network and a replacement policy, make up a full cache; those parts are not included here.

Each cycle the block takes at most one input, chosen by fixed priority: network message first, then voluntary command, then processor request. Every input and output is a valid/ready stream. A transfer happens in a cycle where both valid and ready are high. The sender must hold valid and its payload steady until the transfer happens. An input whose handling must produce an outgoing message waits, with its ready low, until the outgoing register is empty or being drained in that cycle. A load hit waits in the same way for the response register. Outgoing messages and load responses appear in the cycle after the input that caused them. They stay stable while the receiver holds ready low.

A processor miss is not consumed. The block sends the request, enters pending, and holds the processor's ready low until a reply arrives. The same request then completes as a hit.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset the line is invalid (state code 0, where shared=1, exclusive=2, pending=3), line data is zero, and neither output stream is valid.
- R2: In invalid, a processor load sends a shared request (out code 0) and a store sends an exclusive request (out code 1), each with zero data. The line enters pending and the processor request is not accepted.
- R3: While pending, processor ready stays low. In both invalid and pending, writeback requests (in code 0), flush requests (in code 1) and invalidate requests (in code 2) are accepted with no output and no state change.
- R4: A shared reply (in code 3) arriving in invalid or pending loads its data into the line and moves it to shared. An exclusive reply (in code 4) does the same but moves the line to exclusive.
- R5: In shared, a load is accepted and returns the line data one cycle later. A writeback request is ignored. A flush or invalidate request sends an invalidate response (out code 2, zero data) and moves the line to invalid.
- R6: In shared, an exclusive reply moves the line to exclusive and keeps the existing data, ignoring the reply's data. A shared reply is ignored.
- R7: In shared, a store is not accepted. It sends an exclusive request and enters pending. After the exclusive reply arrives, the held store completes and writes its data.
- R8: In exclusive, loads hit, and a store is accepted and writes the line. A writeback request sends a writeback response (out code 3) carrying the line data and moves to shared. A flush request sends a flush response (out code 4) carrying the data and moves to invalid. Invalidate requests and both reply types are ignored.
- R9: Voluntary commands: invalidate (code 0) in shared sends an invalidate response and goes to invalid. Writeback (code 1) in exclusive sends a writeback response with data and goes to shared. Flush (code 2) in exclusive sends a flush response with data and goes to invalid. In any other state the command is accepted with no effect.
- R10: At most one input is accepted per cycle, with network message ahead of voluntary command ahead of processor request.
- R11: A held outgoing message or load response stays valid and unchanged until it is taken. An input that needs the occupied register keeps its ready low, and the line state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Processor request accepted this cycle |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_wdata | input | DATA_W | Store data |
| ld_rsp_valid | output | 1 | Load data present |
| ld_rsp_ready | input | 1 | Processor takes load data |
| ld_rsp_data | output | DATA_W | Load data |
| net_in_valid | input | 1 | Message from home node present |
| net_in_ready | output | 1 | Message consumed |
| net_in_kind | input | 3 | Incoming message code |
| net_in_data | input | DATA_W | Reply data |
| vol_valid | input | 1 | Voluntary command present |
| vol_ready | output | 1 | Voluntary command consumed |
| vol_kind | input | 2 | Voluntary command code |
| net_out_valid | output | 1 | Outgoing message present |
| net_out_ready | input | 1 | Network takes outgoing message |
| net_out_kind | output | 3 | Outgoing message code |
| net_out_data | output | DATA_W | Outgoing data (zero when none) |
| line_state | output | 2 | Current line state code |

## Verification
The bench sweeps every line state against every incoming message, every voluntary command, and both processor operations. After each case it checks the line contents with a load. A design that refilled a shared line on an exclusive reply, or lost the old data on a writeback, would return the wrong load value. A design that consumed a missing request would drop the store that is waiting through the pending window. The bench also drives all three sources together to expose a wrong arbitration order, and holds both output registers full. This catches a block that overwrites a waiting message, or one that changes state while its response has nowhere to go.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHD = 2'd1,
    LS_EXC = 2'd2,
    LS_PND = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    IN_WBREQ  = 3'd0,
    IN_FLREQ  = 3'd1,
    IN_INVREQ = 3'd2,
    IN_SHREP  = 3'd3,
    IN_EXREP  = 3'd4
  } in_msg_e;

  typedef enum logic [1:0] {
    VC_INV   = 2'd0,
    VC_WB    = 2'd1,
    VC_FLUSH = 2'd2
  } vol_e;

  typedef enum logic [2:0] {
    OUT_SHREQ  = 3'd0,
    OUT_EXREQ  = 3'd1,
    OUT_INVREP = 3'd2,
    OUT_WBREP  = 3'd3,
    OUT_FLREP  = 3'd4
  } out_msg_e;
endpackage

// File: rtl/coh_hold_reg.sv
module coh_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         free,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R11: a waiting entry is neither dropped nor altered
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));
  // R11: the producer only writes when the slot can take it
  p_load_when_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);
endmodule

// File: rtl/coh_line_fsm.sv
module coh_line_fsm
  import coh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     msg_valid,
  input  in_msg_e  msg_kind,
  input  logic     vol_valid,
  input  vol_e     vol_kind,
  input  logic     cpu_valid,
  input  logic     cpu_store,
  input  logic     out_free,
  input  logic     rsp_free,
  output line_st_e state,
  output logic     msg_ready,
  output logic     vol_ready,
  output logic     cpu_ready,
  output logic     emit,
  output out_msg_e emit_kind,
  output logic     emit_with_data,
  output logic     fill,
  output logic     wr,
  output logic     ld_hit
);
  line_st_e st, want_st;
  logic want_out, want_data, want_fill, want_wr, want_ld, cons, step_ok, go;
  out_msg_e want_kind;

  always_comb begin
    want_out  = 1'b0;
    want_kind = OUT_SHREQ;
    want_data = 1'b0;
    want_st   = st;
    want_fill = 1'b0;
    want_wr   = 1'b0;
    want_ld   = 1'b0;
    cons      = 1'b1;
    if (msg_valid) begin
      unique case (msg_kind)
        IN_WBREQ: if (st == LS_EXC) begin
          want_out = 1'b1; want_kind = OUT_WBREP; want_data = 1'b1; want_st = LS_SHD;
        end
        IN_FLREQ: if (st == LS_EXC) begin
          want_out = 1'b1; want_kind = OUT_FLREP; want_data = 1'b1; want_st = LS_INV;
        end else if (st == LS_SHD) begin
          want_out = 1'b1; want_kind = OUT_INVREP; want_st = LS_INV;
        end
        IN_INVREQ: if (st == LS_SHD) begin
          want_out = 1'b1; want_kind = OUT_INVREP; want_st = LS_INV;
        end
        IN_SHREP: if (st == LS_INV || st == LS_PND) begin
          want_fill = 1'b1; want_st = LS_SHD;
        end
        IN_EXREP: if (st == LS_INV || st == LS_PND) begin
          want_fill = 1'b1; want_st = LS_EXC;
        end else if (st == LS_SHD) begin
          want_st = LS_EXC;
        end
        default: ;
      endcase
    end else if (vol_valid) begin
      if (vol_kind == VC_INV && st == LS_SHD) begin
        want_out = 1'b1; want_kind = OUT_INVREP; want_st = LS_INV;
      end else if (vol_kind == VC_WB && st == LS_EXC) begin
        want_out = 1'b1; want_kind = OUT_WBREP; want_data = 1'b1; want_st = LS_SHD;
      end else if (vol_kind == VC_FLUSH && st == LS_EXC) begin
        want_out = 1'b1; want_kind = OUT_FLREP; want_data = 1'b1; want_st = LS_INV;
      end
    end else if (cpu_valid) begin
      unique case (st)
        LS_INV: begin
          cons = 1'b0; want_out = 1'b1; want_st = LS_PND;
          want_kind = cpu_store ? OUT_EXREQ : OUT_SHREQ;
        end
        LS_SHD: if (cpu_store) begin
          cons = 1'b0; want_out = 1'b1; want_kind = OUT_EXREQ; want_st = LS_PND;
        end else begin
          want_ld = 1'b1;
        end
        LS_EXC: if (cpu_store) want_wr = 1'b1;
                else           want_ld = 1'b1;
        default: cons = 1'b0;
      endcase
    end
    step_ok   = want_out ? out_free : (want_ld ? rsp_free : 1'b1);
    go        = (msg_valid || vol_valid || cpu_valid) && step_ok;
    msg_ready = msg_valid && step_ok;
    vol_ready = !msg_valid && vol_valid && step_ok;
    cpu_ready = !msg_valid && !vol_valid && cpu_valid && step_ok && cons;
  end

  assign emit           = go && want_out;
  assign emit_kind      = want_kind;
  assign emit_with_data = want_data;
  assign fill           = go && want_fill;
  assign wr             = go && want_wr;
  assign ld_hit         = go && want_ld;
  assign state          = st;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= LS_INV;
    else if (go) st <= want_st;
  end

  // R10: one input source per cycle
  p_one_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_ready, vol_ready, cpu_ready}));
  // R3: processor is stalled while pending
  p_pend_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_PND) |-> !cpu_ready);
  // R2: a request sent from invalid always lands in pending
  p_miss_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_INV && emit) |=> (st == LS_PND));
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_store,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              ld_rsp_valid,
  input  logic              ld_rsp_ready,
  output logic [DATA_W-1:0] ld_rsp_data,
  input  logic              net_in_valid,
  output logic              net_in_ready,
  input  logic [2:0]        net_in_kind,
  input  logic [DATA_W-1:0] net_in_data,
  input  logic              vol_valid,
  output logic              vol_ready,
  input  logic [1:0]        vol_kind,
  output logic              net_out_valid,
  input  logic              net_out_ready,
  output logic [2:0]        net_out_kind,
  output logic [DATA_W-1:0] net_out_data,
  output logic [1:0]        line_state
);
  localparam int OUT_W = 3 + DATA_W;

  line_st_e          st;
  out_msg_e          emit_kind;
  logic              emit, emit_with_data, fill, wr, ld_hit, out_free, rsp_free;
  logic [DATA_W-1:0] line_q;
  logic [OUT_W-1:0]  out_din, out_dout;

  coh_line_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .msg_valid      (net_in_valid),
    .msg_kind       (in_msg_e'(net_in_kind)),
    .vol_valid      (vol_valid),
    .vol_kind       (vol_e'(vol_kind)),
    .cpu_valid      (cpu_req_valid),
    .cpu_store      (cpu_req_store),
    .out_free       (out_free),
    .rsp_free       (rsp_free),
    .state          (st),
    .msg_ready      (net_in_ready),
    .vol_ready      (vol_ready),
    .cpu_ready      (cpu_req_ready),
    .emit           (emit),
    .emit_kind      (emit_kind),
    .emit_with_data (emit_with_data),
    .fill           (fill),
    .wr             (wr),
    .ld_hit         (ld_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    line_q <= '0;
    else if (fill) line_q <= net_in_data;
    else if (wr)   line_q <= cpu_req_wdata;
  end

  assign out_din = {emit_kind, (emit_with_data ? line_q : {DATA_W{1'b0}})};

  coh_hold_reg #(.W(OUT_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (emit),
    .din   (out_din),
    .free  (out_free),
    .valid (net_out_valid),
    .ready (net_out_ready),
    .dout  (out_dout)
  );

  coh_hold_reg #(.W(DATA_W)) u_rsp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ld_hit),
    .din   (line_q),
    .free  (rsp_free),
    .valid (ld_rsp_valid),
    .ready (ld_rsp_ready),
    .dout  (ld_rsp_data)
  );

  assign net_out_kind = out_dout[OUT_W-1:DATA_W];
  assign net_out_data = out_dout[DATA_W-1:0];
  assign line_state   = st;

  // R6: upgrade from shared keeps the existing data
  p_upgrade_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_SHD && net_in_valid && net_in_ready && net_in_kind == 3'd4)
      |=> (st == LS_EXC && $stable(line_q)));
  // R4: a reply in invalid or pending installs its data
  p_reply_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == LS_INV || st == LS_PND) && net_in_valid && net_in_ready &&
     (net_in_kind == 3'd3 || net_in_kind == 3'd4))
      |=> (line_q == $past(net_in_data)));
  // R2: entering pending is always announced on the network
  p_pend_announced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_PND && $past(st) != LS_PND) |-> net_out_valid);
endmodule

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid, cpu_ready, cpu_store;
  logic [DW-1:0] cpu_wdata;
  logic rsp_valid, rsp_ready;
  logic [DW-1:0] rsp_data;
  logic in_valid, in_ready;
  logic [2:0] in_kind;
  logic [DW-1:0] in_data;
  logic v_valid, v_ready;
  logic [1:0] v_kind;
  logic out_valid, out_ready;
  logic [2:0] out_kind;
  logic [DW-1:0] out_data;
  logic [1:0] lstate;

  coh_line_ctrl #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_valid), .cpu_req_ready(cpu_ready),
    .cpu_req_store(cpu_store), .cpu_req_wdata(cpu_wdata),
    .ld_rsp_valid(rsp_valid), .ld_rsp_ready(rsp_ready), .ld_rsp_data(rsp_data),
    .net_in_valid(in_valid), .net_in_ready(in_ready),
    .net_in_kind(in_kind), .net_in_data(in_data),
    .vol_valid(v_valid), .vol_ready(v_ready), .vol_kind(v_kind),
    .net_out_valid(out_valid), .net_out_ready(out_ready),
    .net_out_kind(out_kind), .net_out_data(out_data),
    .line_state(lstate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_line;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cpu_valid = 0; cpu_store = 0; cpu_wdata = '0;
    in_valid = 0; in_kind = '0; in_data = '0;
    v_valid = 0; v_kind = '0;
    out_ready = 1; rsp_ready = 1;
  endtask

  task automatic goto_state(input int s, input logic [DW-1:0] d);
    rst_n = 0; idle(); tick(); tick(); rst_n = 1; tick();
    exp_line = '0;
    if (s == 1 || s == 2) begin
      in_valid = 1; in_kind = (s == 1) ? 3'd3 : 3'd4; in_data = d;
      tick(); in_valid = 0; exp_line = d;
    end else if (s == 3) begin
      cpu_valid = 1; cpu_store = 0;
      tick(); cpu_valid = 0; tick();
    end
    check("R4", "setup state", lstate, s);
  endtask

  task automatic check_load(input string req);
    cpu_valid = 1; cpu_store = 0;
    #1 check(req, "load ready", cpu_ready, 1);
    tick();
    check(req, "load valid", rsp_valid, 1);
    check(req, "load data", rsp_data, exp_line);
    cpu_valid = 0;
    tick();
  endtask

  initial begin
    idle();
    tick(); tick();
    // R1: reset state
    check("R1", "state", lstate, 0);
    check("R1", "out valid", out_valid, 0);
    check("R1", "rsp valid", rsp_valid, 0);
    rst_n = 1; tick();
    check("R1", "state after release", lstate, 0);

    // Sweep: every state against every incoming message
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k++) begin
        logic [DW-1:0] md;
        int ns, ek, ed;
        logic em;
        string tg;
        goto_state(s, DW'(8'h30 + s * 5 + k));
        md = DW'(8'hA0 + s * 5 + k);
        ns = s; em = 0; ek = 0; ed = 0;
        if (s == 1) tg = (k >= 3) ? "R6" : "R5";
        else if (s == 2) tg = "R8";
        else tg = (k >= 3) ? "R4" : "R3";
        case (k)
          0: if (s == 2) begin ns = 1; em = 1; ek = 3; ed = exp_line; end
          1: if (s == 2) begin ns = 0; em = 1; ek = 4; ed = exp_line; end
             else if (s == 1) begin ns = 0; em = 1; ek = 2; end
          2: if (s == 1) begin ns = 0; em = 1; ek = 2; end
          3: if (s == 0 || s == 3) begin ns = 1; exp_line = md; end
          default: if (s == 0 || s == 3) begin ns = 2; exp_line = md; end
                   else if (s == 1) ns = 2;
        endcase
        in_valid = 1; in_kind = 3'(k); in_data = md;
        #1 check(tg, "msg ready", in_ready, 1);
        tick();
        in_valid = 0;
        check(tg, "msg next state", lstate, ns);
        check(tg, "msg out valid", out_valid, int'(em));
        if (em) begin
          check(tg, "msg out kind", out_kind, ek);
          check(tg, "msg out data", out_data, ed);
        end
        tick();
        if (ns == 1 || ns == 2) check_load(tg);
      end
    end

    // Sweep: every state against every voluntary command (R9)
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 3; v++) begin
        int ns, ek, ed;
        logic em;
        goto_state(s, DW'(8'h50 + s * 3 + v));
        ns = s; em = 0; ek = 0; ed = 0;
        if (v == 0 && s == 1) begin ns = 0; em = 1; ek = 2; end
        if (v == 1 && s == 2) begin ns = 1; em = 1; ek = 3; ed = exp_line; end
        if (v == 2 && s == 2) begin ns = 0; em = 1; ek = 4; ed = exp_line; end
        v_valid = 1; v_kind = 2'(v);
        #1 check("R9", "vol ready", v_ready, 1);
        tick();
        v_valid = 0;
        check("R9", "vol next state", lstate, ns);
        check("R9", "vol out valid", out_valid, int'(em));
        if (em) begin
          check("R9", "vol out kind", out_kind, ek);
          check("R9", "vol out data", out_data, ed);
        end
        tick();
        if (ns == 1 || ns == 2) check_load("R9");
      end
    end

    // Sweep: every state against load and store
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 2; w++) begin
        logic [DW-1:0] wd;
        goto_state(s, DW'(8'h70 + s * 2 + w));
        wd = DW'(8'hC0 + s * 2 + w);
        cpu_valid = 1; cpu_store = w[0]; cpu_wdata = wd;
        if (s == 0) begin
          #1 check("R2", "miss ready", cpu_ready, 0);
          tick(); cpu_valid = 0;
          check("R2", "miss state", lstate, 3);
          check("R2", "miss out valid", out_valid, 1);
          check("R2", "miss out kind", out_kind, w);
          check("R2", "miss out data", out_data, 0);
          tick();
        end else if (s == 3) begin
          #1 check("R3", "pending ready", cpu_ready, 0);
          tick(); cpu_valid = 0;
          check("R3", "pending state", lstate, 3);
          check("R3", "pending no out", out_valid, 0);
        end else if (w == 0) begin
          cpu_valid = 0;
          check_load(s == 1 ? "R5" : "R8");
        end else if (s == 2) begin
          #1 check("R8", "store ready", cpu_ready, 1);
          tick(); cpu_valid = 0; exp_line = wd;
          check("R8", "store state", lstate, 2);
          check_load("R8");
        end else begin
          #1 check("R7", "upgrade ready", cpu_ready, 0);
          tick();
          check("R7", "upgrade state", lstate, 3);
          check("R7", "upgrade out kind", out_kind, 1);
          check("R7", "upgrade out valid", out_valid, 1);
          in_valid = 1; in_kind = 3'd4; in_data = 8'h3C;
          #1 check("R7", "held store while reply", cpu_ready, 0);
          tick(); in_valid = 0;
          check("R7", "after reply state", lstate, 2);
          #1 check("R7", "held store completes", cpu_ready, 1);
          tick(); cpu_valid = 0; exp_line = wd;
          check_load("R7");
        end
      end
    end

    // R10: priority among simultaneous sources
    goto_state(2, 8'h99);
    in_valid = 1; in_kind = 3'd0; v_valid = 1; v_kind = 2'd2; cpu_valid = 1; cpu_store = 0;
    #1 check("R10", "msg wins", in_ready, 1);
    check("R10", "vol waits", v_ready, 0);
    check("R10", "cpu waits", cpu_ready, 0);
    tick(); in_valid = 0;
    check("R10", "msg applied", lstate, 1);
    check("R10", "msg out kind", out_kind, 3);
    #1 check("R10", "vol next", v_ready, 1);
    check("R10", "cpu still waits", cpu_ready, 0);
    tick(); v_valid = 0;
    check("R10", "vol no effect in shared", lstate, 1);
    #1 check("R10", "cpu last", cpu_ready, 1);
    tick(); cpu_valid = 0;
    check("R10", "cpu load data", rsp_data, 8'h99);

    // R11: outgoing register held full
    goto_state(2, 8'h5A);
    out_ready = 0;
    in_valid = 1; in_kind = 3'd0;
    #1 check("R11", "first accepted", in_ready, 1);
    tick();
    in_kind = 3'd1;
    check("R11", "wbrep out", out_kind, 3);
    #1 check("R11", "blocked while full", in_ready, 0);
    tick();
    check("R11", "state held", lstate, 1);
    check("R11", "out held valid", out_valid, 1);
    check("R11", "out held kind", out_kind, 3);
    check("R11", "out held data", out_data, 8'h5A);
    out_ready = 1;
    #1 check("R11", "unblocked", in_ready, 1);
    tick(); in_valid = 0;
    check("R11", "inv rep next", out_kind, 2);
    check("R11", "state invalid", lstate, 0);

    // R11: load response register held full
    goto_state(2, 8'hE7);
    rsp_ready = 0; cpu_valid = 1; cpu_store = 0;
    #1 check("R11", "first load ready", cpu_ready, 1);
    tick();
    #1 check("R11", "second load blocked", cpu_ready, 0);
    tick();
    check("R11", "rsp held", rsp_valid, 1);
    check("R11", "rsp data held", rsp_data, 8'hE7);
    cpu_valid = 0; rsp_ready = 1;
    tick();
    check("R11", "rsp drained", rsp_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule